// File: doc/BRIEF.md
# Clock Divider Counter Configuration Encoder

This block turns a requested divide ratio for one output divider of a clock synthesizer into the three 16-bit counter-configuration words that the synthesizer's divider expects. The ratio has an integer part and a fractional part counted in eighths. From these the block derives the counter high time and low time, the odd-count edge flag, the bypass (no-count) flag, the fractional enable and value, the rising and falling waveform-correction flags, and the fractional phase. A second operation runs the other way. It takes a pair of packed words and rebuilds the integer divide value that they encode. The encode operation reports this same rebuilt value for the words it has just produced.

Requests arrive on a valid/ready handshake. The control state machine has two states. ST_IDLE accepts a request and raises `in_ready`. ST_HOLD presents the registered result on `out_valid` and lowers `in_ready`. The transition ACCEPT (ST_IDLE to ST_HOLD) is taken when `in_valid` and `in_ready` are both high. The transition RELEASE (ST_HOLD to ST_IDLE) is taken when `out_ready` is high. Without a request, ST_IDLE stays in ST_IDLE. Without an acknowledge, ST_HOLD stays in ST_HOLD.

Field layout:
- Word A: high count in bits 11:6, low count in bits 5:0.
- Word B: fraction in bits 14:12, fractional enable in bit 11, rise flag in bit 10, edge in bit 7, no-count in bit 6.
- Word C: phase in bits 13:11, fall flag in bit 10.

All other bits are zero.

Top module: `clkdiv_cfg_enc`

## Requirements
- R1: With fraction 0 and an integer divide d of 2 or more, high = floor(d/2), low = d − high, and edge = d mod 2.
- R2: With fraction 0 and an integer divide of 1 or 0, the no-count bit (word B bit 6) is set, high = 1, low = 1, and edge = 0.
- R3: An integer divide above 126 is clamped to 126, which gives high = 63 and low = 63.
- R4: With a nonzero fraction f, edge = d mod 2 and high = low = floor(d/2). Then, when edge is 0, high is reduced by one and the rise flag (word B bit 10) is set. When edge is 0 or f = 1, low is reduced by one.
- R5: With a nonzero fraction, the fall flag (word C bit 10) is set when exactly one of "edge is 0" and "f = 1" is true. It is also set when d = 2 and f = 1.
- R6: With a nonzero fraction, word B carries f in bits 14:12 and the fractional enable in bit 11, and word C carries phase = edge*4 + floor(f/2) in bits 13:11.
- R7: With fraction 0, the fraction field, the fractional enable, the rise flag, the fall flag and the phase are all 0, so word C is 0.
- R8: With a nonzero fraction, an integer divide below 2 is raised to 2.
- R9: The decode operation (`in_decode` = 1) returns word A and word B unchanged and word C as 0. Its value is 1 if word B bit 6 is set. Otherwise it is word A bits 5:0 plus word A bits 11:6, and word A bits 15:12 have no effect. An encode operation reports the same rebuilt value for its own words.
- R10: A result appears on `out_valid` one cycle after a request is accepted. It holds steady until `out_ready` is seen, and no new request is accepted while it is held.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_decode | input | 1 | 0 = encode a ratio, 1 = decode packed words |
| in_div_int | input | 7 | Integer part of the divide ratio |
| in_div_frac | input | 3 | Fractional part in eighths |
| in_word_a | input | 16 | Word A to decode |
| in_word_b | input | 16 | Word B to decode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word_a | output | 16 | High and low counts |
| out_word_b | output | 16 | Fraction, enable, rise flag, edge, no-count |
| out_word_c | output | 16 | Phase and fall flag |
| out_div | output | 7 | Rebuilt integer divide value |

## Verification
The bench builds the block with the package's 6-bit count fields. With that width the clamp value is 126, so the clamp boundary and the case where both fields are full can be reached with a 7-bit input. Since the fraction is 3 bits wide, each parity of the integer part can be combined with the fractions 1, 4 and 6, which reach every branch of the fall-flag rule and the top phase value. The table also covers the raised divide and the underflow to a zero high count at ratio 2 1/8.

// File: rtl/clkdiv_cfg_pkg.sv
package clkdiv_cfg_pkg;
    localparam int FLD_W   = 6;
    localparam int DIV_W   = FLD_W + 1;
    localparam int FRAC_W  = 3;
    localparam int WORD_W  = 16;
    localparam int PH_W    = 3;
    localparam int MAX_DIV = 2 * ((1 << FLD_W) - 1);

    // word A
    localparam int A_LO_LSB  = 0;
    localparam int A_HI_LSB  = FLD_W;
    // word B
    localparam int B_NOCNT   = 6;
    localparam int B_EDGE    = 7;
    localparam int B_RISE    = 10;
    localparam int B_FEN     = 11;
    localparam int B_FRAC_LSB = 12;
    // word C
    localparam int C_FALL    = 10;
    localparam int C_PH_LSB  = 11;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/clkdiv_cfg_fields.sv
module clkdiv_cfg_fields
    import clkdiv_cfg_pkg::*;
(
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b,
    output logic [WORD_W-1:0] word_c
);
    logic [DIV_W-1:0] d;
    logic [DIV_W-1:0] hi;
    logic [DIV_W-1:0] lo;
    logic             frac_mode;
    logic             frac_one;
    logic             edge_b;
    logic             nocnt;
    logic             rise;
    logic             fall;
    logic [PH_W-1:0]  phase;

    always_comb begin
        frac_mode = |div_frac;
        frac_one  = (div_frac == FRAC_W'(1));
        d = div_int;
        if (d == '0)
            d = DIV_W'(1);
        if (d > DIV_W'(MAX_DIV))
            d = DIV_W'(MAX_DIV);
        if (frac_mode && d < DIV_W'(2))
            d = DIV_W'(2);

        hi     = d >> 1;
        lo     = '0;
        edge_b = d[0];
        nocnt  = 1'b0;
        rise   = 1'b0;
        fall   = 1'b0;
        phase  = '0;

        if (!frac_mode) begin
            if (d == DIV_W'(1)) begin
                hi     = DIV_W'(1);
                lo     = DIV_W'(1);
                nocnt  = 1'b1;
                edge_b = 1'b0;
            end else begin
                lo = d - hi;
            end
        end else begin
            lo = hi;
            if (!edge_b) begin
                hi   = hi - DIV_W'(1);
                rise = 1'b1;
            end
            if (!edge_b || frac_one)
                lo = lo - DIV_W'(1);
            fall  = ((!edge_b) ^ frac_one) || (d == DIV_W'(2) && frac_one);
            phase = {edge_b, div_frac[FRAC_W-1:1]};
        end
    end

    always_comb begin
        word_a = '0;
        word_a[A_LO_LSB +: FLD_W] = lo[FLD_W-1:0];
        word_a[A_HI_LSB +: FLD_W] = hi[FLD_W-1:0];

        word_b = '0;
        word_b[B_FRAC_LSB +: FRAC_W] = div_frac;
        word_b[B_FEN]   = frac_mode;
        word_b[B_RISE]  = rise;
        word_b[B_EDGE]  = edge_b;
        word_b[B_NOCNT] = nocnt;

        word_c = '0;
        word_c[C_PH_LSB +: PH_W] = phase;
        word_c[C_FALL] = fall;
    end

    logic unused_bits;
    assign unused_bits = ^{hi[DIV_W-1], lo[DIV_W-1]};
endmodule

// File: rtl/clkdiv_cfg_decode.sv
module clkdiv_cfg_decode
    import clkdiv_cfg_pkg::*;
(
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic [DIV_W-1:0]  div_val
);
    logic [FLD_W-1:0] lo_f;
    logic [FLD_W-1:0] hi_f;

    assign lo_f = word_a[A_LO_LSB +: FLD_W];
    assign hi_f = word_a[A_HI_LSB +: FLD_W];

    always_comb begin
        if (word_b[B_NOCNT])
            div_val = DIV_W'(1);
        else
            div_val = DIV_W'(lo_f) + DIV_W'(hi_f);
    end

    logic unused_bits;
    assign unused_bits = ^{word_a[WORD_W-1:2*FLD_W], word_b[WORD_W-1:B_NOCNT+1],
                           word_b[B_NOCNT-1:0]};
endmodule

// File: rtl/clkdiv_cfg_enc.sv
module clkdiv_cfg_enc
    import clkdiv_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_decode,
    input  logic [DIV_W-1:0]     in_div_int,
    input  logic [FRAC_W-1:0]    in_div_frac,
    input  logic [WORD_W-1:0]    in_word_a,
    input  logic [WORD_W-1:0]    in_word_b,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_word_a,
    output logic [WORD_W-1:0]    out_word_b,
    output logic [WORD_W-1:0]    out_word_c,
    output logic [DIV_W-1:0]     out_div
);
    ctl_state_t state_q, state_d;

    logic [WORD_W-1:0] enc_a, enc_b, enc_c;
    logic [WORD_W-1:0] sel_a, sel_b, sel_c;
    logic [DIV_W-1:0]  dec_div;
    logic              accept;

    clkdiv_cfg_fields u_fields (
        .div_int  (in_div_int),
        .div_frac (in_div_frac),
        .word_a   (enc_a),
        .word_b   (enc_b),
        .word_c   (enc_c)
    );

    assign sel_a = in_decode ? in_word_a : enc_a;
    assign sel_b = in_decode ? in_word_b : enc_b;
    assign sel_c = in_decode ? '0        : enc_c;

    clkdiv_cfg_decode u_decode (
        .word_a  (sel_a),
        .word_b  (sel_b),
        .div_val (dec_div)
    );

    // next state: ACCEPT and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_HOLD;
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_HOLD);
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word_a <= '0;
            out_word_b <= '0;
            out_word_c <= '0;
            out_div    <= '0;
        end else if (accept) begin
            out_word_a <= sel_a;
            out_word_b <= sel_b;
            out_word_c <= sel_c;
            out_div    <= dec_div;
        end
    end
endmodule

// File: rtl/clkdiv_cfg_enc_chk.sv
module clkdiv_cfg_enc_chk
    import clkdiv_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word_a,
    input logic [WORD_W-1:0] out_word_b,
    input logic [WORD_W-1:0] out_word_c,
    input logic [DIV_W-1:0]  out_div
);
    assert_accept_to_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word_a)
            && $stable(out_word_b) && $stable(out_word_c) && $stable(out_div)));

    assert_no_accept_while_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && in_ready));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    assert_nocount_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word_b[B_NOCNT]) |-> (out_div == DIV_W'(1)));

    assert_frac_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word_b[B_FEN]) |-> (out_word_b[B_FRAC_LSB +: FRAC_W] != '0));
endmodule

bind clkdiv_cfg_enc clkdiv_cfg_enc_chk chk_i (.*);

// File: tb/clkdiv_cfg_enc_tb_top.sv
`timescale 1ns/1ps
module clkdiv_cfg_enc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_decode = 1'b0;
    logic [6:0]  in_div_int = '0;
    logic [2:0]  in_div_frac = '0;
    logic [15:0] in_word_a = '0;
    logic [15:0] in_word_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_word_a, out_word_b, out_word_c;
    logic [6:0]  out_div;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    clkdiv_cfg_enc dut_i (.*);

    typedef struct packed {
        logic        dec;
        logic [6:0]  di;
        logic [2:0]  fr;
        logic [15:0] iwa;
        logic [15:0] iwb;
        logic [15:0] ewa;
        logic [15:0] ewb;
        logic [15:0] ewc;
        logic [6:0]  ediv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'd1,   3'd0, 16'h0, 16'h0, 16'h0041, 16'h0040, 16'h0000, 7'd1,   4'd2},  // R2 divide 1
        '{1'b0, 7'd0,   3'd0, 16'h0, 16'h0, 16'h0041, 16'h0040, 16'h0000, 7'd1,   4'd2},  // R2 divide 0
        '{1'b0, 7'd2,   3'd0, 16'h0, 16'h0, 16'h0041, 16'h0000, 16'h0000, 7'd2,   4'd1},  // R1 even
        '{1'b0, 7'd7,   3'd0, 16'h0, 16'h0, 16'h00C4, 16'h0080, 16'h0000, 7'd7,   4'd1},  // R1 odd, R7
        '{1'b0, 7'd126, 3'd0, 16'h0, 16'h0, 16'h0FFF, 16'h0000, 16'h0000, 7'd126, 4'd3},  // R3 at limit
        '{1'b0, 7'd127, 3'd0, 16'h0, 16'h0, 16'h0FFF, 16'h0000, 16'h0000, 7'd126, 4'd3},  // R3 clamp
        '{1'b0, 7'd4,   3'd4, 16'h0, 16'h0, 16'h0041, 16'h4C00, 16'h1400, 7'd2,   4'd4},  // R4 even
        '{1'b0, 7'd5,   3'd1, 16'h0, 16'h0, 16'h0081, 16'h1880, 16'h2400, 7'd3,   4'd5},  // R5 odd f=1
        '{1'b0, 7'd2,   3'd1, 16'h0, 16'h0, 16'h0000, 16'h1C00, 16'h0400, 7'd0,   4'd5},  // R5 d=2 f=1
        '{1'b0, 7'd3,   3'd6, 16'h0, 16'h0, 16'h0041, 16'h6880, 16'h3800, 7'd2,   4'd6},  // R6 phase 7
        '{1'b0, 7'd6,   3'd1, 16'h0, 16'h0, 16'h0082, 16'h1C00, 16'h0000, 7'd4,   4'd5},  // R5 even f=1
        '{1'b0, 7'd1,   3'd3, 16'h0, 16'h0, 16'h0000, 16'h3C00, 16'h0C00, 7'd0,   4'd8},  // R8 raised
        '{1'b1, 7'd0,   3'd0, 16'h00C4, 16'h0000, 16'h00C4, 16'h0000, 16'h0000, 7'd7,   4'd9}, // R9
        '{1'b1, 7'd9,   3'd5, 16'h0FFF, 16'h0040, 16'h0FFF, 16'h0040, 16'h0000, 7'd1,   4'd9}, // R9 nocount
        '{1'b1, 7'd0,   3'd0, 16'h0FFF, 16'h0000, 16'h0FFF, 16'h0000, 16'h0000, 7'd126, 4'd9}, // R9 full
        '{1'b1, 7'd0,   3'd0, 16'hF03F, 16'h0000, 16'hF03F, 16'h0000, 16'h0000, 7'd63,  4'd9}  // R9 top bits
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input vec_t v);
        @(negedge clk);
        in_valid    = 1'b1;
        in_decode   = v.dec;
        in_div_int  = v.di;
        in_div_frac = v.fr;
        in_word_a   = v.iwa;
        in_word_b   = v.iwb;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 out_valid in reset", 32'(out_valid), 32'd0);
        check("R11 in_ready in reset", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 out_valid after reset", 32'(out_valid), 32'd0);
        check("R11 in_ready after reset", 32'(in_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", VECS[i].req, i);
            send(VECS[i]);
            check({t, " valid"}, 32'(out_valid), 32'd1);
            check({t, " word_a"}, 32'(out_word_a), 32'(VECS[i].ewa));
            check({t, " word_b"}, 32'(out_word_b), 32'(VECS[i].ewb));
            check({t, " word_c"}, 32'(out_word_c), 32'(VECS[i].ewc));
            check({t, " div"}, 32'(out_div), 32'(VECS[i].ediv));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            check({t, " released"}, 32'(out_valid), 32'd0);
        end

        // R10 hold without acknowledge, new request ignored while held
        send(VECS[3]);
        in_valid    = 1'b1;
        in_decode   = 1'b0;
        in_div_int  = 7'd10;
        in_div_frac = 3'd0;
        repeat (3) begin
            @(negedge clk);
            check("R10 held valid", 32'(out_valid), 32'd1);
            check("R10 ready low while held", 32'(in_ready), 32'd0);
            check("R10 held word_a", 32'(out_word_a), 32'h00C4);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R10 release", 32'(out_valid), 32'd0);
        check("R10 ready after release", 32'(in_ready), 32'd1);

        // R10 back-to-back: request waiting while held is accepted after release
        send(VECS[2]);
        in_valid    = 1'b1;
        in_div_int  = 7'd9;
        in_div_frac = 3'd0;
        out_ready   = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R10 idle after release", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 queued d=9 word_a", 32'(out_word_a), 32'h0105);
        check("R1 queued d=9 div", 32'(out_div), 32'd9);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;

        // R11 reset while holding
        send(VECS[0]);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule